// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Snapshot

The block counts elapsed time from a 32.768 kHz enable input. A fractional accumulator turns that enable into millisecond steps. The steps drive a milliseconds-within-second counter and a seconds counter. Both are read through a single read port, with one port for the read strobe and one for the byte address.

Software that wants a timestamp cannot get one safely by reading live seconds and milliseconds one after the other, because a rollover may fall between the two reads. The block avoids this with a snapshot. Any read of the milliseconds register also copies the seconds value of that same instant into a separate snapshot register. Reading milliseconds first and the snapshot second therefore gives a pair that belongs together. The total in milliseconds is snapshot × 1000 + milliseconds.

Top module: `rtc_snapshot_counter`

## Requirements
- R1: After reset, every register reads 0 and `rd_valid_o` is low.
- R2: The milliseconds counter runs from 0 to MS_PER_SEC-1 (default 999). A millisecond step taken at MS_PER_SEC-1 returns it to 0 and adds one to seconds on the same clock edge.
- R3: Each sampled `tick32k_i` adds 1000 to an accumulator. When the sum reaches 32768, the accumulator keeps the remainder and one millisecond step follows. That step changes the counters on the edge after the edge that sampled the enable. Exactly 32768 enables from reset give 1 second and 0 milliseconds.
- R4: When `rd_en_i` is sampled high on an edge, `rd_valid_o` is high after that edge. `rd_data_o` then holds the addressed register as it was before that edge. With no read, `rd_valid_o` is low.
- R5: The byte addresses are fixed: 0x08 returns live seconds, 0x0C returns snapshot seconds and 0x10 returns milliseconds. Values are zero-extended to 32 bits. Any other address returns 0.
- R6: A read of 0x10 loads the snapshot with the seconds value from the same state as the returned milliseconds. This also holds on the edge where milliseconds roll over.
- R7: The snapshot keeps its value until the next read of 0x10. Reads of 0x08, 0x0C or any other address change no register.
- R8: Seconds is SEC_W bits wide (default 32) and wraps modulo 2^SEC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick32k_i | input | 1 | One-cycle enable at 32.768 kHz |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W (8) | Byte address of the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | DATA_W (32) | Read data |

## Verification
The bench drives a dense enable pattern (an enable every cycle) to check the exact 32768-enable to one-second ratio. It also drives a sparse random enable pattern, which exercises accumulator carries at uneven spacing. Random reads of all three mapped addresses and of unmapped ones separate a correct snapshot from one that is loaded by the wrong read, and from a read that has side effects. A directed milliseconds read on the rollover edge, followed by reads of live seconds and of the snapshot, separates a coherent snapshot from one that takes the already incremented seconds. A second instance with a 2-bit seconds field and a 10-step millisecond period shows the seconds wrap within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [31:0] OFFS_LIVE_SEC = 32'h08;
    localparam logic [31:0] OFFS_SNAP_SEC = 32'h0C;
    localparam logic [31:0] OFFS_MILLI    = 32'h10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LIVE,
        SEL_SNAP,
        SEL_MILLI
    } rtc_sel_e;

    function automatic rtc_sel_e rtc_decode(input logic [31:0] addr);
        rtc_sel_e s;
        s = SEL_NONE;
        if (addr == OFFS_LIVE_SEC) s = SEL_LIVE;
        else if (addr == OFFS_SNAP_SEC) s = SEL_SNAP;
        else if (addr == OFFS_MILLI) s = SEL_MILLI;
        return s;
    endfunction

endpackage

// File: rtl/rtc_ms_pulse.sv
module rtc_ms_pulse #(
    parameter int INC = 1000,
    parameter int MOD = 32768
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic pulse_o
);
    localparam int ACC_W = $clog2(MOD + INC);
    localparam logic [ACC_W-1:0] INC_C = ACC_W'(INC);
    localparam logic [ACC_W-1:0] MOD_C = ACC_W'(MOD);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pulse;
    } st_t;

    st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        sum        = st_q.acc + INC_C;
        if (tick_i) begin
            if (sum >= MOD_C) begin
                st_d.acc   = sum - MOD_C;
                st_d.pulse = 1'b1;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // R3: remainder always stays below the modulus
    p_acc_below_mod_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.acc < MOD_C);
    // R3: a step only follows a sampled enable
    p_pulse_after_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> !pulse_o);
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32,
    localparam int MS_W      = $clog2(MS_PER_SEC)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [MS_W-1:0]  ms_o,
    output logic [SEC_W-1:0] sec_o
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    typedef struct packed {
        logic [MS_W-1:0]  ms;
        logic [SEC_W-1:0] sec;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) begin
            if (cnt_q.ms == MS_LAST) begin
                cnt_d.ms  = '0;
                cnt_d.sec = cnt_q.sec + 1'b1;
            end else begin
                cnt_d.ms = cnt_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign ms_o  = cnt_q.ms;
    assign sec_o = cnt_q.sec;

    // R2: milliseconds never leave their range
    p_ms_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q.ms <= MS_LAST);
    // R2/R8: rollover clears ms and bumps seconds (modulo) on the same edge
    p_rollover_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && cnt_q.ms == MS_LAST) |=>
        (cnt_q.ms == '0 && cnt_q.sec == SEC_W'($past(cnt_q.sec) + 1'b1)));
    // R3: without a step nothing moves
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> ($stable(cnt_q.ms) && $stable(cnt_q.sec)));
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SEC_W  = 32,
    parameter int MS_W   = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [MS_W-1:0]   ms_i,
    input  logic [SEC_W-1:0]  sec_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [SEC_W-1:0]  snap;
        logic [DATA_W-1:0] data;
        logic              valid;
    } rp_t;

    rp_t rp_d, rp_q;
    rtc_sel_e sel;

    always_comb begin
        sel         = rtc_decode(32'(rd_addr_i));
        rp_d        = rp_q;
        rp_d.valid  = rd_en_i;
        if (rd_en_i) begin
            unique case (sel)
                SEL_LIVE:  rp_d.data = DATA_W'(sec_i);
                SEL_SNAP:  rp_d.data = DATA_W'(rp_q.snap);
                SEL_MILLI: begin
                    rp_d.data = DATA_W'(ms_i);
                    rp_d.snap = sec_i;
                end
                default:   rp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rp_q <= '0;
        else         rp_q <= rp_d;
    end

    assign rd_valid_o = rp_q.valid;
    assign rd_data_o  = rp_q.data;

    // R6: a milliseconds read captures the seconds of that same state
    p_snap_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && sel == SEL_MILLI) |=> (rp_q.snap == $past(sec_i)));
    // R7: any other cycle leaves the snapshot alone
    p_snap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_en_i && sel == SEL_MILLI) |=> $stable(rp_q.snap));
    // R4: valid follows the strobe by one edge
    p_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_valid_o);
endmodule

// File: rtl/rtc_snapshot_counter.sv
module rtc_snapshot_counter #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int SEC_W      = 32,
    parameter int MS_PER_SEC = 1000,
    parameter int FRAC_INC   = 1000,
    parameter int FRAC_MOD   = 32768
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick32k_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int MS_W = $clog2(MS_PER_SEC);

    logic             ms_step;
    logic [MS_W-1:0]  ms_val;
    logic [SEC_W-1:0] sec_val;

    rtc_ms_pulse #(.INC(FRAC_INC), .MOD(FRAC_MOD)) u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick32k_i),
        .pulse_o (ms_step)
    );

    rtc_time_count #(.MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)) u_count (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (ms_step),
        .ms_o   (ms_val),
        .sec_o  (sec_val)
    );

    rtc_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)) u_read (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .ms_i       (ms_val),
        .sec_i      (sec_val),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    // R1: no read data is flagged out of reset
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !rd_valid_o);
endmodule

// File: tb/rtc_snapshot_counter_tb_top.sv
module rtc_snapshot_counter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic v0, v1;
    logic [31:0] d0, d1;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_snapshot_counter dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick32k_i(tick),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_valid_o(v0), .rd_data_o(d0));

    // short-period instance used to reach the seconds wrap (R8)
    rtc_snapshot_counter #(.SEC_W(2), .MS_PER_SEC(10)) dut_w_i (
        .clk_i(clk), .rst_ni(rst_n), .tick32k_i(tick),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_valid_o(v1), .rd_data_o(d1));

    // behavioural reference model
    longint m_acc;
    bit     m_pend;
    longint m_ms[2], m_sec[2], m_snap[2], m_data[2];
    bit     m_valid;
    int     m_addr;
    longint ms_mod[2] = '{1000, 10};
    longint sec_mod[2] = '{64'd1 << 32, 4};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_pend = 0; m_valid = 0; m_addr = 0;
            for (int i = 0; i < 2; i++) begin
                m_ms[i] = 0; m_sec[i] = 0; m_snap[i] = 0; m_data[i] = 0;
            end
        end else begin
            m_valid = rd_en;
            if (rd_en) m_addr = rd_addr;
            for (int i = 0; i < 2; i++) begin
                if (rd_en) begin
                    if (rd_addr == 8'h08) m_data[i] = m_sec[i];
                    else if (rd_addr == 8'h0C) m_data[i] = m_snap[i];
                    else if (rd_addr == 8'h10) begin
                        m_data[i] = m_ms[i];
                        m_snap[i] = m_sec[i];
                    end else m_data[i] = 0;
                end
                if (m_pend) begin
                    m_ms[i] = m_ms[i] + 1;
                    if (m_ms[i] == ms_mod[i]) begin
                        m_ms[i] = 0;
                        m_sec[i] = (m_sec[i] + 1) % sec_mod[i];
                    end
                end
            end
            m_pend = 0;
            if (tick) begin
                m_acc = m_acc + 1000;
                if (m_acc >= 32768) begin
                    m_acc = m_acc - 32768;
                    m_pend = 1;
                end
            end
        end
    end

    function automatic string tag_of(int a);
        if (a == 8'h08) return "R2";
        if (a == 8'h0C) return "R7";
        if (a == 8'h10) return "R6";
        return "R5";
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare against the model on every clock (at the negedge)
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R4 valid", longint'(v0), longint'(m_valid));
            check("R4 valid w", longint'(v1), longint'(m_valid));
            if (m_valid) begin
                check(tag_of(m_addr), longint'(d0), m_data[0]);
                check({tag_of(m_addr), "/R8 w"}, longint'(d1), m_data[1]);
            end
        end
    end

    task automatic rd(input logic [7:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        longint old_sec;
        int guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", longint'(v0), 0);
        rd(8'h08); check("R1 live", longint'(d0), 0);
        rd(8'h0C); check("R1 snap", longint'(d0), 0);
        rd(8'h10); check("R1 ms", longint'(d0), 0);
        cmp_on = 1'b1;

        // R3: 32768 enables give exactly one second
        tick = 1'b1;
        repeat (32768) @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h08); check("R3 live sec", longint'(d0), 1);
        rd(8'h10); check("R3 ms", longint'(d0), 0);

        // random sparse enables and mixed reads
        for (int n = 0; n < 40000; n++) begin
            tick = ($urandom % 4) != 0;
            if (($urandom % 3) == 0) begin
                case ($urandom % 6)
                    0: rd_addr = 8'h08;
                    1: rd_addr = 8'h0C;
                    2: rd_addr = 8'h10;
                    3: rd_addr = 8'h04;
                    4: rd_addr = 8'h14;
                    default: rd_addr = 8'h00;
                endcase
                rd_en = 1'b1;
            end else rd_en = 1'b0;
            @(negedge clk);
        end
        rd_en = 1'b0;

        // R6: milliseconds read on the rollover edge
        tick = 1'b1;
        guard = 0;
        while (!(m_pend && m_ms[0] == 999) && guard < 40000) begin
            @(negedge clk); guard++;
        end
        check("R6 found rollover", longint'(guard < 40000), 1);
        old_sec = m_sec[0];
        rd(8'h10); check("R6 ms at rollover", longint'(d0), 999);
        rd(8'h08); check("R2 live advanced", longint'(d0), old_sec + 1);
        rd(8'h14); check("R5 unmapped zero", longint'(d0), 0);
        rd(8'h0C); check("R6 snap coherent", longint'(d0), old_sec);
        repeat (100) @(negedge clk);
        rd(8'h0C); check("R7 snap held", longint'(d0), old_sec);

        // more random traffic with dense enables
        for (int n = 0; n < 20000; n++) begin
            rd_en = ($urandom % 2) == 1;
            rd_addr = (($urandom % 2) == 1) ? 8'h10 : 8'h0C;
            @(negedge clk);
        end
        rd_en = 1'b0;
        tick = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h08); check("R8 wrap instance live", longint'(d1), m_sec[1]);
        finish_run();
    end
endmodule